// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds the current time of day and calendar date as binary-coded decimal registers: seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week index. An external tick enable feeds a small phase divider. Once every `TICKS_PER_SEC` ticks the block steps the time by one second. The step carries through the minutes, hours, date, month and year. It follows the real length of each month, including a 29th of February in leap years. The hour register selects its own format: 24-hour, or 12-hour with a PM flag.

Software reaches the fields through a byte-wide register port. A field write is accepted only while the external unlock input is high. An accepted write freezes counting until the surrounding bus transaction completes. The transaction-complete strobe then zeroes the sub-second phase, so the first step comes a full second after the time was set. Reads are served from a shadow copy that is taken on a read-start strobe. A multi-byte read therefore always sees one coherent moment, even if the clock steps during the read.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x12 (12-hour format, AM), date 0x01, month 0x01, year 0x00 and day of week 0x00. Register addresses are 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year and 6 day of week.
- R2: Seconds and minutes count in BCD from 00 to 59. Each wraps to 00 and carries to the next field. The time steps by one second on every `TICKS_PER_SEC`-th tick pulse.
- R3: When hour bit 7 is 1 the hour counts in 24-hour BCD from 00 to 23, with bit 5 as the high bit of the tens digit. 23 wraps to 00 and starts a new day.
- R4: When hour bit 7 is 0 the hour counts 1 to 12 in bits 4..0, with bit 5 set for PM. 11 AM steps to 12 PM (0x32) and 12 PM steps to 1 PM (0x21). 11 PM (0x31) steps to 12 AM (0x12) and starts a new day.
- R5: The date wraps to 0x01 after day 30 of April, June, September and November, and after day 31 of the other months except February.
- R6: February ends on day 29 when the year value is divisible by 4, and on day 28 otherwise.
- R7: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R8: Day of week is a 3-bit counter from 0 to 6. It steps once per new day and wraps from 6 to 0.
- R9: A field write while the unlock input is 0 leaves every field unchanged.
- R10: An accepted write halts counting until the transaction-complete strobe. The strobe zeroes the sub-second phase, so the first step occurs on the `TICKS_PER_SEC`-th tick after it.
- R11: A read-start pulse copies all fields into a shadow. Read data comes from the shadow alone and keeps its value until the next read-start pulse.
- R12: Address 7 ignores writes and reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Sub-second tick enable, one cycle per tick |
| wr_unlock | input | 1 | Permits field writes when high |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address for the write |
| wr_data | input | 8 | BCD data to write |
| xfer_done | input | 1 | Bus transaction completed |
| rd_start | input | 1 | Captures all fields into the read shadow |
| rd_addr | input | 3 | Field address for the read |
| rd_data | output | 8 | Shadowed field value |

## Verification
The range assertions assume that software writes only legal BCD values: a date that exists in the written month, an hour that is valid for its format, and a day of week no greater than 6. The counter never produces an illegal value by itself, but it does not clean one up after a bad write. The stimulus therefore writes only legal field values. It raises `xfer_done` only in a cycle without a write, and it drives all inputs half a cycle away from the sampling edge. The bench model steps a behavioural integer calendar and compares the shadowed read data on every clock.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
        logic [2:0] dow;
    } cal_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h12,
                                   date: 8'h01, mon: 8'h01, year: 8'h00,
                                   dow: 3'd0};

    localparam int FIELD_CNT = 7;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic year_is_leap(input logic [7:0] y);
        logic [7:0] bin;
        bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
        return bin[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] m,
                                                  input logic [7:0] y);
        logic [7:0] r;
        case (m)
            8'h02:                      r = year_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_phase.sv
module rtc_tick_phase #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wr_ok,
    input  logic xfer_done,
    output logic sec_step
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } ph_t;

    ph_t ph_d, ph_q;
    logic step_d;

    always_comb begin
        ph_d   = ph_q;
        step_d = 1'b0;
        if (wr_ok) begin
            ph_d.pend = 1'b1;
        end else if (xfer_done && ph_q.pend) begin
            ph_d.pend = 1'b0;
            ph_d.cnt  = '0;
        end else if (tick_en && !ph_q.pend) begin
            if (ph_q.cnt == LAST) begin
                ph_d.cnt = '0;
                step_d   = 1'b1;
            end else begin
                ph_d.cnt = ph_q.cnt + 1'b1;
            end
        end
    end

    assign sec_step = step_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '{cnt: '0, pend: 1'b0};
        else        ph_q <= ph_d;
    end

    // R10
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q.pend && xfer_done && !wr_ok) |=> (ph_q.cnt == '0 && !ph_q.pend));

    // R10
    hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ok) |-> !sec_step);

endmodule

// File: rtl/rtc_time_advance.sv
module rtc_time_advance
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [1:0] tens24;
    logic       pm;

    always_comb begin
        nxt    = cur;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        tens24 = {cur.hour[5], cur.hour[4]};
        pm     = cur.hour[5];

        if (cur.sec == 8'h59) begin
            nxt.sec = 8'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = bcd_inc(cur.sec);
        end

        if (c_min) begin
            if (cur.min == 8'h59) begin
                nxt.min = 8'h00;
                c_hour  = 1'b1;
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end

        if (c_hour) begin
            if (cur.hour[7]) begin
                if (tens24 == 2'd2 && cur.hour[3:0] == 4'd3) begin
                    nxt.hour = 8'h80;
                    c_day    = 1'b1;
                end else if (cur.hour[3:0] == 4'd9) begin
                    tens24   = tens24 + 2'd1;
                    nxt.hour = {1'b1, 1'b0, tens24, 4'd0};
                end else begin
                    nxt.hour = {1'b1, 1'b0, tens24, cur.hour[3:0] + 4'd1};
                end
            end else begin
                if (cur.hour[4] && cur.hour[3:0] == 4'd1) begin
                    nxt.hour = {2'b00, ~pm, 5'h12};
                    c_day    = pm;
                end else if (cur.hour[4] && cur.hour[3:0] == 4'd2) begin
                    nxt.hour = {2'b00, pm, 5'h01};
                end else if (cur.hour[3:0] == 4'd9) begin
                    nxt.hour = {2'b00, pm, 5'h10};
                end else begin
                    nxt.hour = {2'b00, pm, cur.hour[4], cur.hour[3:0] + 4'd1};
                end
            end
        end

        if (c_day) begin
            nxt.dow = (cur.dow == 3'd6) ? 3'd0 : cur.dow + 3'd1;
            if (cur.date == month_last_day(cur.mon, cur.year)) begin
                nxt.date = 8'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.date = bcd_inc(cur.date);
            end
        end

        if (c_mon) begin
            if (cur.mon == 8'h12) begin
                nxt.mon = 8'h01;
                c_year  = 1'b1;
            end else begin
                nxt.mon = bcd_inc(cur.mon);
            end
        end

        if (c_year) begin
            nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
        end
    end

endmodule

// File: rtl/rtc_read_shadow.sv
module rtc_read_shadow
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_start,
    input  cal_t       live,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    cal_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (rd_start) snap_d = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= CAL_RESET;
        else        snap_q <= snap_d;
    end

    always_comb begin
        case (rd_addr)
            3'd0:    rd_data = snap_q.sec;
            3'd1:    rd_data = snap_q.min;
            3'd2:    rd_data = snap_q.hour;
            3'd3:    rd_data = snap_q.date;
            3'd4:    rd_data = snap_q.mon;
            3'd5:    rd_data = snap_q.year;
            3'd6:    rd_data = {5'd0, snap_q.dow};
            default: rd_data = 8'h00;
        endcase
    end

    // R11
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> snap_q == $past(live));

    // R11
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> $stable(snap_q));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_unlock,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       xfer_done,
    input  logic       rd_start,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam logic [2:0] LAST_FIELD = 3'(FIELD_CNT - 1);

    cal_t time_d, time_q, adv_time;
    logic wr_ok;
    logic sec_step;

    assign wr_ok = wr_en && wr_unlock && (wr_addr <= LAST_FIELD);

    rtc_tick_phase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_ok    (wr_ok),
        .xfer_done(xfer_done),
        .sec_step (sec_step)
    );

    rtc_time_advance u_adv (
        .cur(time_q),
        .nxt(adv_time)
    );

    always_comb begin
        time_d = time_q;
        if (wr_ok) begin
            case (wr_addr)
                3'd0:    time_d.sec  = {1'b0, wr_data[6:0]};
                3'd1:    time_d.min  = {1'b0, wr_data[6:0]};
                3'd2:    time_d.hour = {wr_data[7], 1'b0, wr_data[5:0]};
                3'd3:    time_d.date = {2'b00, wr_data[5:0]};
                3'd4:    time_d.mon  = {3'b000, wr_data[4:0]};
                3'd5:    time_d.year = wr_data;
                default: time_d.dow  = wr_data[2:0];
            endcase
        end else if (sec_step) begin
            time_d = adv_time;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= CAL_RESET;
        else        time_q <= time_d;
    end

    rtc_read_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_start(rd_start),
        .live    (time_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R8
    dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_q.dow <= 3'd6);

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_q.sec <= 8'h59 && time_q.sec[3:0] <= 4'd9);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_unlock) && !sec_step) |=> time_q == $past(time_q));

    // R4
    hour12_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !time_q.hour[7] |-> (time_q.hour[4:0] != 5'h00 && time_q.hour[4:0] <= 5'h12));

    // R7
    month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_q.mon != 8'h00 && time_q.mon <= 8'h12);

endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, wr_unlock = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       xfer_done = 1'b0, rd_start = 1'b1;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 0;
    bit auto_addr = 1'b1;
    logic [2:0] sel_addr = '0;
    int cyc = 0;

    rtc_calendar_core #(.TICKS_PER_SEC(TPS)) u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_unlock(wr_unlock),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .xfer_done(xfer_done), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    // behavioural model
    logic [7:0] m [0:6];
    logic [7:0] snap [0:6];
    int m_phase;
    bit m_pend;
    logic [7:0] masks [0:6] = '{8'h7F, 8'h7F, 8'hBF, 8'h3F, 8'h1F, 8'hFF, 8'h07};

    function automatic int b2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] i2b(int v);
        logic [7:0] r;
        r[7:4] = 4'(v / 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    task automatic model_reset();
        m = '{8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00};
        snap = m;
        m_phase = 0;
        m_pend = 0;
    endtask

    task automatic model_step();
        int s, mi, v, d, mo, yr, md;
        bit cm, ch, cd, cmo, cy, pm;
        cm = 0; ch = 0; cd = 0; cmo = 0; cy = 0;
        s = b2i(m[0]) + 1;
        if (s == 60) begin s = 0; cm = 1; end
        m[0] = i2b(s);
        if (cm) begin
            mi = b2i(m[1]) + 1;
            if (mi == 60) begin mi = 0; ch = 1; end
            m[1] = i2b(mi);
        end
        if (ch) begin
            if (m[2][7]) begin
                v = (int'(m[2][5]) * 2 + int'(m[2][4])) * 10 + int'(m[2][3:0]) + 1;
                if (v == 24) begin v = 0; cd = 1; end
                m[2] = 8'h80 | i2b(v);
            end else begin
                v = int'(m[2][4]) * 10 + int'(m[2][3:0]);
                pm = m[2][5];
                if (v == 11) begin v = 12; cd = pm; pm = !pm; end
                else if (v == 12) v = 1;
                else v = v + 1;
                m[2] = {2'b00, pm, i2b(v)[4:0]};
            end
        end
        if (cd) begin
            m[6] = 8'((int'(m[6]) + 1) % 7);
            mo = b2i(m[4]);
            yr = b2i(m[5]);
            if (mo == 2) md = (yr % 4 == 0) ? 29 : 28;
            else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) md = 30;
            else md = 31;
            d = b2i(m[3]) + 1;
            if (d > md) begin d = 1; cmo = 1; end
            m[3] = i2b(d);
        end
        if (cmo) begin
            mo = b2i(m[4]) + 1;
            if (mo == 13) begin mo = 1; cy = 1; end
            m[4] = i2b(mo);
        end
        if (cy) m[5] = i2b((b2i(m[5]) + 1) % 100);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            if (rd_start) snap = m;
            if (wr_en && wr_unlock && wr_addr < 3'd7) begin
                m[wr_addr] = wr_data & masks[wr_addr];
                m_pend = 1;
            end else if (xfer_done && m_pend) begin
                m_pend = 0;
                m_phase = 0;
            end else if (tick_en && !m_pend) begin
                m_phase = m_phase + 1;
                if (m_phase == TPS) begin
                    m_phase = 0;
                    model_step();
                end
            end
        end
    end

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        rd_addr = auto_addr ? 3'(cyc % 8) : sel_addr;
        #1;
        if (rst_n && !done) begin
            if (rd_addr == 3'd7) chk("model R12", rd_data, 8'h00);
            else                 chk("model R2", rd_data, snap[rd_addr]);
        end
    end

    task automatic cyc_wait(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic xfer();
        @(negedge clk);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                            logic [7:0] d, logic [7:0] mo, logic [7:0] y,
                            logic [7:0] w);
        wr_unlock = 1;
        wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, w);
        wr_unlock = 0;
        xfer();
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [7:0] exp);
        auto_addr = 0;
        sel_addr = a;
        cyc_wait(2);
        #2;
        chk(tag, rd_data, exp);
        auto_addr = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc_wait(3);
        rst_n = 1;
        cyc_wait(2);
        // R1 reset values
        rd_chk("R1 sec", 0, 8'h00);
        rd_chk("R1 min", 1, 8'h00);
        rd_chk("R1 hour", 2, 8'h12);
        rd_chk("R1 date", 3, 8'h01);
        rd_chk("R1 month", 4, 8'h01);
        rd_chk("R1 year", 5, 8'h00);
        rd_chk("R1 dow", 6, 8'h00);

        // R9 locked write ignored
        wr_unlock = 0;
        wr(0, 8'h30);
        xfer();
        rd_chk("R9 sec locked", 0, 8'h00);

        // R2 seconds step after TPS ticks, with phase restart
        set_time(8'h09, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00);
        ticks(TPS - 1);
        rd_chk("R10 no step before full second", 0, 8'h09);
        ticks(1);
        rd_chk("R2 sec 09->10", 0, 8'h10);

        // R3 R7 R8 end of century in 24h mode
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06);
        ticks(TPS);
        rd_chk("R2 sec wrap", 0, 8'h00);
        rd_chk("R2 min wrap", 1, 8'h00);
        rd_chk("R3 hour 23->00", 2, 8'h80);
        rd_chk("R7 date", 3, 8'h01);
        rd_chk("R7 month 12->01", 4, 8'h01);
        rd_chk("R7 year 99->00", 5, 8'h00);
        rd_chk("R8 dow 6->0", 6, 8'h00);

        // R3 tens carry 19->20
        set_time(8'h59, 8'h59, 8'h99, 8'h10, 8'h03, 8'h05, 8'h02);
        ticks(TPS);
        rd_chk("R3 hour 19->20", 2, 8'hA0);

        // R6 leap and non-leap February
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h01);
        ticks(TPS);
        rd_chk("R6 leap 28->29", 3, 8'h29);
        rd_chk("R6 leap month", 4, 8'h02);
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h01);
        ticks(TPS);
        rd_chk("R6 common 28->01", 3, 8'h01);
        rd_chk("R6 common month", 4, 8'h03);

        // R5 month lengths
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h10, 8'h03);
        ticks(TPS);
        rd_chk("R5 april 30->01", 3, 8'h01);
        rd_chk("R5 april->may", 4, 8'h05);
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h01, 8'h10, 8'h03);
        ticks(TPS);
        rd_chk("R5 january 30->31", 3, 8'h31);
        rd_chk("R8 dow 3->4", 6, 8'h04);

        // R4 12-hour sequence
        set_time(8'h59, 8'h59, 8'h11, 8'h05, 8'h06, 8'h20, 8'h02);
        ticks(TPS);
        rd_chk("R4 11AM->12PM", 2, 8'h32);
        rd_chk("R4 no new day at noon", 3, 8'h05);
        set_time(8'h59, 8'h59, 8'h32, 8'h05, 8'h06, 8'h20, 8'h02);
        ticks(TPS);
        rd_chk("R4 12PM->1PM", 2, 8'h21);
        set_time(8'h59, 8'h59, 8'h31, 8'h05, 8'h06, 8'h20, 8'h02);
        ticks(TPS);
        rd_chk("R4 11PM->12AM", 2, 8'h12);
        rd_chk("R4 new day date", 3, 8'h06);
        rd_chk("R8 dow 2->3", 6, 8'h03);

        // R10 counting held while write pending
        wr_unlock = 1;
        wr(0, 8'h40);
        wr_unlock = 0;
        ticks(3 * TPS);
        rd_chk("R10 held while pending", 0, 8'h40);
        xfer();
        ticks(TPS);
        rd_chk("R10 resumes after strobe", 0, 8'h41);

        // R11 shadow holds without read start
        @(negedge clk);
        rd_start = 0;
        ticks(2 * TPS);
        rd_chk("R11 shadow frozen", 0, 8'h41);
        @(negedge clk);
        rd_start = 1;
        rd_chk("R11 shadow refreshed", 0, 8'h43);

        // R12 address 7
        wr_unlock = 1;
        wr(7, 8'h55);
        wr_unlock = 0;
        xfer();
        rd_chk("R12 addr7 reads zero", 7, 8'h00);
        rd_chk("R12 sec unchanged", 0, 8'h43);

        cyc_wait(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule